// File: doc/BRIEF.md
# Alarm, Countdown Timer and Interrupt Controller

This block sits beside a calendar counter chain and turns time-of-day information into interrupt events. It takes the current minute, hour, day and weekday as inputs and compares them with a set of alarm values. Each alarm field has its own enable, and the block flags an alarm only on the first cycle of a match. It also runs a countdown timer from one of four tick sources and turns the calendar's second and minute strobes into a periodic event flag.

Three sticky flags record these events: a periodic flag, an alarm flag and a timer flag. Software clears them with a masked write. A 1 in a bit position keeps that flag and a 0 clears it, so clearing one flag never disturbs another. The interrupt line is active-low and open-drain in style: it is either pulled low or released. It works in one of two modes. In level mode it follows the enabled flags. In pulse mode each new event gives a low pulse of fixed width, and clearing the flag ends that pulse early.

Register decoding happens outside the block. Configuration arrives as held inputs, and writes arrive as single-cycle strobes.

Top module: `alarm_timer_irq`

## Requirements
- R1: After reset all flags are 0, the countdown value is 0 and `irq_no` is 1 (released).
- R2: `flags_o` holds the timer flag in bit 0, the alarm flag in bit 1 and the periodic flag in bit 2. On a `flag_wr_i` strobe each flag becomes its old value ANDed with the matching bit of `flag_wdata_i`, so writing 1 keeps a flag and writing 0 clears it.
- R3: A `sec_tick_i` strobe sets the periodic flag when `sec_irq_en_i` is 1. A `min_tick_i` strobe sets it when `min_irq_en_i` is 1. The two enables act independently.
- R4: `alarm_en_i` bit 0 enables the minute comparison, bit 1 the hour, bit 2 the day and bit 3 the weekday. The alarm matches when every enabled field equals the current time. With no field enabled, the alarm never matches.
- R5: The alarm flag is set only in the cycle in which the match begins. While the match persists, a cleared alarm flag stays cleared.
- R6: On each selected tick with the timer enabled, the count drops by one. A tick that finds the count at 1 reloads the last loaded value and sets the timer flag. A count of 0 stays at 0.
- R7: `timer_src_i` selects the tick source: 0 is the 4.096 kHz tick, 1 the 64 Hz tick, 2 the second tick and 3 the minute tick. Ticks from sources that are not selected have no effect.
- R8: `timer_load_i` writes `timer_value_i` into both the count and the reload value at the next edge. It takes effect at once, even mid-period, and takes priority over a tick in the same cycle.
- R9: While `timer_en_i` is 0 the count holds its value.
- R10: The periodic flag drives the interrupt when either periodic enable is 1. The alarm flag drives it when `alarm_irq_en_i` is 1, and the timer flag when `timer_irq_en_i` is 1. In level mode (`pulse_mode_i`=0), `irq_no` is 0 exactly while an enabled flag is 1.
- R11: In pulse mode, each event that sets an enabled flag pulls `irq_no` low for PULSE_W cycles, starting in the cycle the flag becomes visible. Clearing that flag ends its pulse in the same cycle.
- R12: When an event sets a flag in the same cycle that a write clears it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cur_min_i | input | 7 | Current minute |
| cur_hour_i | input | 6 | Current hour |
| cur_day_i | input | 6 | Current day of month |
| cur_wday_i | input | 3 | Current weekday |
| alarm_min_i | input | 7 | Alarm minute |
| alarm_hour_i | input | 6 | Alarm hour |
| alarm_day_i | input | 6 | Alarm day |
| alarm_wday_i | input | 3 | Alarm weekday |
| alarm_en_i | input | 4 | Per-field alarm enables |
| tick_4k_i | input | 1 | 4.096 kHz tick strobe |
| tick_64_i | input | 1 | 64 Hz tick strobe |
| sec_tick_i | input | 1 | Seconds strobe from the calendar |
| min_tick_i | input | 1 | Minutes strobe from the calendar |
| sec_irq_en_i | input | 1 | Periodic event on seconds |
| min_irq_en_i | input | 1 | Periodic event on minutes |
| alarm_irq_en_i | input | 1 | Alarm interrupt enable |
| timer_irq_en_i | input | 1 | Timer interrupt enable |
| pulse_mode_i | input | 1 | 1 = pulse interrupt, 0 = level |
| timer_en_i | input | 1 | Countdown enable |
| timer_src_i | input | 2 | Countdown source select |
| timer_load_i | input | 1 | Countdown value write strobe |
| timer_value_i | input | 8 | Countdown value to write |
| flag_wr_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 3 | Flag write mask |
| flags_o | output | 3 | Flags {periodic, alarm, timer} |
| timer_cnt_o | output | 8 | Current countdown value |
| irq_no | output | 1 | Active-low interrupt |

## Verification
The hardest case to reach is the alarm's first-match rule together with the early end of a pulse. Both need a flag to be cleared while its cause stays active. The stimulus holds the current time equal to the alarm across many cycles and clears the alarm flag in the middle of that window. It then breaks and re-makes the match to show that a new rising edge is needed. In pulse mode it re-arms the alarm and clears the flag one cycle into the pulse. A behavioural model updated on every edge is checked against all outputs on every cycle.

// File: rtl/alarm_timer_pkg.sv
package alarm_timer_pkg;
  localparam int unsigned FLAG_TF   = 0;
  localparam int unsigned FLAG_AF   = 1;
  localparam int unsigned FLAG_MSF  = 2;
  localparam int unsigned NUM_FLAGS = 3;

  typedef enum logic [1:0] {
    SRC_4K  = 2'd0,
    SRC_64  = 2'd1,
    SRC_SEC = 2'd2,
    SRC_MIN = 2'd3
  } tmr_src_e;
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
  parameter int unsigned W = 7
) (
  input  logic         en_i,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] ref_i,
  output logic         ok_o
);
  assign ok_o = !en_i || (cur_i == ref_i);
endmodule

// File: rtl/alarm_unit.sv
module alarm_unit #(
  parameter int unsigned MIN_W  = 7,
  parameter int unsigned HOUR_W = 6,
  parameter int unsigned DAY_W  = 6,
  parameter int unsigned WDAY_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MIN_W-1:0]  cur_min_i,
  input  logic [HOUR_W-1:0] cur_hour_i,
  input  logic [DAY_W-1:0]  cur_day_i,
  input  logic [WDAY_W-1:0] cur_wday_i,
  input  logic [MIN_W-1:0]  alm_min_i,
  input  logic [HOUR_W-1:0] alm_hour_i,
  input  logic [DAY_W-1:0]  alm_day_i,
  input  logic [WDAY_W-1:0] alm_wday_i,
  input  logic [3:0]        en_i,
  output logic              hit_o,
  output logic              set_o
);
  logic [3:0] ok;
  logic       hit_q;

  alarm_field_cmp #(.W(MIN_W))  u_min  (.en_i(en_i[0]), .cur_i(cur_min_i),  .ref_i(alm_min_i),  .ok_o(ok[0]));
  alarm_field_cmp #(.W(HOUR_W)) u_hour (.en_i(en_i[1]), .cur_i(cur_hour_i), .ref_i(alm_hour_i), .ok_o(ok[1]));
  alarm_field_cmp #(.W(DAY_W))  u_day  (.en_i(en_i[2]), .cur_i(cur_day_i),  .ref_i(alm_day_i),  .ok_o(ok[2]));
  alarm_field_cmp #(.W(WDAY_W)) u_wday (.en_i(en_i[3]), .cur_i(cur_wday_i), .ref_i(alm_wday_i), .ok_o(ok[3]));

  // all-disabled never matches
  assign hit_o = (|en_i) && (&ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q <= 1'b0;
    else         hit_q <= hit_o;
  end

  assign set_o = hit_o && !hit_q;
endmodule

// File: rtl/countdown_timer.sv
module countdown_timer
  import alarm_timer_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  tmr_src_e     src_i,
  input  logic         tick_4k_i,
  input  logic         tick_64_i,
  input  logic         tick_sec_i,
  input  logic         tick_min_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic         expire_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, reload_q;
  logic         tick_sel;

  always_comb begin
    unique case (src_i)
      SRC_4K:  tick_sel = tick_4k_i;
      SRC_64:  tick_sel = tick_64_i;
      SRC_SEC: tick_sel = tick_sec_i;
      default: tick_sel = tick_min_i;
    endcase
  end

  wire step = en_i && tick_sel && !load_i;
  assign expire_o = step && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      reload_q <= '0;
    end else if (load_i) begin
      cnt_q    <= load_val_i;
      reload_q <= load_val_i;
    end else if (expire_o) begin
      cnt_q    <= reload_q;
    end else if (step && cnt_q != '0) begin
      cnt_q    <= cnt_q - ONE;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/irq_pulse.sv
module irq_pulse #(
  parameter int unsigned PULSE_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic flag_next_i,
  output logic active_o
);
  localparam int unsigned CW = $clog2(PULSE_W + 1);
  localparam logic [CW-1:0] LEN = CW'(PULSE_W);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (set_i)          cnt_q <= LEN;
    else if (!flag_next_i)   cnt_q <= '0;   // flag cleared cuts pulse
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/alarm_timer_irq.sv
module alarm_timer_irq
  import alarm_timer_pkg::*;
#(
  parameter int unsigned MIN_W   = 7,
  parameter int unsigned HOUR_W  = 6,
  parameter int unsigned DAY_W   = 6,
  parameter int unsigned WDAY_W  = 3,
  parameter int unsigned TMR_W   = 8,
  parameter int unsigned PULSE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MIN_W-1:0]  cur_min_i,
  input  logic [HOUR_W-1:0] cur_hour_i,
  input  logic [DAY_W-1:0]  cur_day_i,
  input  logic [WDAY_W-1:0] cur_wday_i,
  input  logic [MIN_W-1:0]  alarm_min_i,
  input  logic [HOUR_W-1:0] alarm_hour_i,
  input  logic [DAY_W-1:0]  alarm_day_i,
  input  logic [WDAY_W-1:0] alarm_wday_i,
  input  logic [3:0]        alarm_en_i,
  input  logic              tick_4k_i,
  input  logic              tick_64_i,
  input  logic              sec_tick_i,
  input  logic              min_tick_i,
  input  logic              sec_irq_en_i,
  input  logic              min_irq_en_i,
  input  logic              alarm_irq_en_i,
  input  logic              timer_irq_en_i,
  input  logic              pulse_mode_i,
  input  logic              timer_en_i,
  input  logic [1:0]        timer_src_i,
  input  logic              timer_load_i,
  input  logic [TMR_W-1:0]  timer_value_i,
  input  logic              flag_wr_i,
  input  logic [2:0]        flag_wdata_i,
  output logic [2:0]        flags_o,
  output logic [TMR_W-1:0]  timer_cnt_o,
  output logic              irq_no
);
  logic [NUM_FLAGS-1:0] flags_q, flags_d, set_vec, irq_en, pulse_act, src_on;
  logic                 alarm_hit, alarm_set, tmr_expire;

  alarm_unit #(.MIN_W(MIN_W), .HOUR_W(HOUR_W), .DAY_W(DAY_W), .WDAY_W(WDAY_W)) u_alarm (
    .clk_i, .rst_ni,
    .cur_min_i, .cur_hour_i, .cur_day_i, .cur_wday_i,
    .alm_min_i(alarm_min_i), .alm_hour_i(alarm_hour_i),
    .alm_day_i(alarm_day_i), .alm_wday_i(alarm_wday_i),
    .en_i(alarm_en_i), .hit_o(alarm_hit), .set_o(alarm_set)
  );

  countdown_timer #(.W(TMR_W)) u_timer (
    .clk_i, .rst_ni,
    .en_i(timer_en_i), .src_i(tmr_src_e'(timer_src_i)),
    .tick_4k_i, .tick_64_i, .tick_sec_i(sec_tick_i), .tick_min_i(min_tick_i),
    .load_i(timer_load_i), .load_val_i(timer_value_i),
    .cnt_o(timer_cnt_o), .expire_o(tmr_expire)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[FLAG_TF]  = tmr_expire;
    set_vec[FLAG_AF]  = alarm_set;
    set_vec[FLAG_MSF] = (sec_irq_en_i && sec_tick_i) || (min_irq_en_i && min_tick_i);
    irq_en            = '0;
    irq_en[FLAG_TF]   = timer_irq_en_i;
    irq_en[FLAG_AF]   = alarm_irq_en_i;
    irq_en[FLAG_MSF]  = sec_irq_en_i || min_irq_en_i;
    // masked clear; a set in the same cycle wins
    flags_d = (flag_wr_i ? (flags_q & flag_wdata_i) : flags_q) | set_vec;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_pulse
    irq_pulse #(.PULSE_W(PULSE_W)) u_pulse (
      .clk_i, .rst_ni,
      .set_i(set_vec[g]), .flag_next_i(flags_d[g]), .active_o(pulse_act[g])
    );
  end

  assign src_on      = pulse_mode_i ? pulse_act : flags_q;
  assign irq_no      = !(|(src_on & irq_en));
  assign flags_o     = flags_q;
endmodule

// File: rtl/alarm_timer_irq_chk.sv
module alarm_timer_irq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] flags_o,
  input logic       flag_wr_i,
  input logic [2:0] flag_wdata_i,
  input logic       alarm_hit,
  input logic       timer_en_i,
  input logic       timer_load_i,
  input logic [7:0] timer_value_i,
  input logic [7:0] timer_cnt_o,
  input logic       pulse_mode_i,
  input logic       irq_no
);
  assert_flag_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flags_o[1]) |-> $past(flag_wr_i && !flag_wdata_i[1]));

  assert_alarm_needs_hit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[1]) |-> $past(alarm_hit));

  assert_load_now_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timer_load_i |=> (timer_cnt_o == $past(timer_value_i)));

  assert_hold_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!timer_en_i && !timer_load_i) |=> $stable(timer_cnt_o));

  assert_level_needs_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_mode_i && !irq_no) |-> (|flags_o));

  assert_pulse_needs_flag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_mode_i && !irq_no) |-> (|flags_o));
endmodule

bind alarm_timer_irq alarm_timer_irq_chk u_chk (
  .clk_i, .rst_ni, .flags_o, .flag_wr_i, .flag_wdata_i,
  .alarm_hit, .timer_en_i, .timer_load_i, .timer_value_i,
  .timer_cnt_o, .pulse_mode_i, .irq_no
);

// File: tb/alarm_timer_irq_test.sv
module alarm_timer_irq_test;
  localparam int PW = 4;

  logic clk = 0, rst_n = 0;
  logic [6:0] cur_min = 0, alm_min = 0;
  logic [5:0] cur_hour = 0, cur_day = 1, alm_hour = 0, alm_day = 1;
  logic [2:0] cur_wday = 0, alm_wday = 0;
  logic [3:0] alm_en = 0;
  logic t4k = 0, t64 = 0, tsec = 0, tmin = 0;
  logic si_en = 0, mi_en = 0, aie = 0, tie = 0, pmode = 0, ten = 0;
  logic [1:0] tsrc = 0;
  logic tload = 0, fwr = 0;
  logic [7:0] tval = 0;
  logic [2:0] fwd = 0;
  logic [2:0] flags;
  logic [7:0] tcnt;
  logic irq_n;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  alarm_timer_irq #(.PULSE_W(PW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cur_min_i(cur_min), .cur_hour_i(cur_hour), .cur_day_i(cur_day), .cur_wday_i(cur_wday),
    .alarm_min_i(alm_min), .alarm_hour_i(alm_hour), .alarm_day_i(alm_day), .alarm_wday_i(alm_wday),
    .alarm_en_i(alm_en), .tick_4k_i(t4k), .tick_64_i(t64), .sec_tick_i(tsec), .min_tick_i(tmin),
    .sec_irq_en_i(si_en), .min_irq_en_i(mi_en), .alarm_irq_en_i(aie), .timer_irq_en_i(tie),
    .pulse_mode_i(pmode), .timer_en_i(ten), .timer_src_i(tsrc), .timer_load_i(tload),
    .timer_value_i(tval), .flag_wr_i(fwr), .flag_wdata_i(fwd),
    .flags_o(flags), .timer_cnt_o(tcnt), .irq_no(irq_n)
  );

  // behavioural reference
  bit   m_f[3];
  int   m_cnt, m_rel, m_pulse[3];
  bit   m_prev;

  function automatic bit m_match();
    bit any = 0, ok = 1;
    if (alm_en[0]) begin any = 1; if (cur_min  != alm_min)  ok = 0; end
    if (alm_en[1]) begin any = 1; if (cur_hour != alm_hour) ok = 0; end
    if (alm_en[2]) begin any = 1; if (cur_day  != alm_day)  ok = 0; end
    if (alm_en[3]) begin any = 1; if (cur_wday != alm_wday) ok = 0; end
    return any && ok;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_f[i]) begin m_f[i] = 0; m_pulse[i] = 0; end
      m_cnt = 0; m_rel = 0; m_prev = 0;
    end else begin
      bit sets[3];
      bit mt, tk;
      mt = m_match();
      sets[1] = mt && !m_prev;
      m_prev = mt;
      sets[2] = (si_en && tsec) || (mi_en && tmin);
      case (tsrc) 0: tk = t4k; 1: tk = t64; 2: tk = tsec; default: tk = tmin; endcase
      sets[0] = 0;
      if (tload) begin m_cnt = tval; m_rel = tval; end
      else if (ten && tk) begin
        if (m_cnt == 1) begin m_cnt = m_rel; sets[0] = 1; end
        else if (m_cnt != 0) m_cnt = m_cnt - 1;
      end
      for (int i = 0; i < 3; i++) begin
        if (fwr && !fwd[i]) m_f[i] = 0;
        if (sets[i]) m_f[i] = 1;
        if (sets[i]) m_pulse[i] = PW;
        else if (!m_f[i]) m_pulse[i] = 0;
        else if (m_pulse[i] > 0) m_pulse[i] = m_pulse[i] - 1;
      end
    end
  end

  function automatic bit m_irq_n();
    bit en[3], act = 0;
    en[0] = tie; en[1] = aie; en[2] = si_en || mi_en;
    for (int i = 0; i < 3; i++)
      if (en[i] && (pmode ? (m_pulse[i] > 0) : m_f[i])) act = 1;
    return !act;
  endfunction

  always @(negedge clk) if (rst_n) begin
    logic [2:0] ef;
    ef = {m_f[2], m_f[1], m_f[0]};
    n_chk++;
    if (flags !== ef || tcnt !== 8'(m_cnt) || irq_n !== m_irq_n()) begin
      n_fail++;
      $display("FAIL %s: flags/cnt/irq_n actual %b/%0d/%b expected %b/%0d/%b",
               cur_req, flags, tcnt, irq_n, ef, m_cnt, m_irq_n());
    end
  end

  task automatic cyc(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_flags(logic [2:0] m);
    fwr = 1; fwd = m; cyc(1); fwr = 0;
  endtask

  task automatic tick(ref logic t);
    t = 1; cyc(1); t = 0;
  endtask

  initial begin
    fork
      begin
        #3000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    join_none

    cyc(3); rst_n = 1; cyc(1);
    cur_req = "R1";
    chk("R1 flags", flags, 0); chk("R1 cnt", tcnt, 0); chk("R1 irq", irq_n, 1);

    // R3 periodic flag
    cur_req = "R3";
    si_en = 1; tick(tsec);
    chk("R3 sec sets MSF", flags, 3'b100); chk("R10 level irq", irq_n, 0);
    cur_req = "R2";
    wr_flags(3'b011); chk("R2 clear MSF", flags, 0);
    cur_req = "R3";
    si_en = 0; mi_en = 1; tick(tsec); chk("R3 sec disabled", flags, 0);
    tick(tmin); chk("R3 min sets MSF", flags, 3'b100);
    wr_flags(3'b011);

    // R12 set beats clear
    cur_req = "R12";
    tmin = 1; fwr = 1; fwd = 3'b000; cyc(1); tmin = 0; fwr = 0;
    chk("R12 set wins", flags, 3'b100);
    wr_flags(3'b011); mi_en = 0;

    // R4/R5 alarm
    cur_req = "R4";
    alm_min = 30; alm_hour = 7; cur_hour = 5;
    alm_en = 4'b0011; cur_min = 30; cyc(3); chk("R4 hour mismatch", flags, 0);
    alm_en = 4'b0000; cyc(2); chk("R4 none enabled", flags, 0);
    alm_en = 4'b0001; cyc(1); chk("R4 min only", flags, 3'b010);
    cur_req = "R2";
    wr_flags(3'b110); chk("R2 TF clear keeps AF", flags, 3'b010);
    cur_req = "R5";
    cyc(2); wr_flags(3'b101); cyc(4); chk("R5 no re-set while held", flags, 0);
    cur_min = 31; cyc(2); cur_min = 30; cyc(1); chk("R5 new match", flags, 3'b010);
    wr_flags(3'b101); cur_min = 0;

    // R6/R7 timer
    cur_req = "R6";
    tsrc = 2'd0; ten = 1; tval = 3; tload = 1; cyc(1); tload = 0;
    chk("R8 load", tcnt, 3);
    tick(t4k); chk("R6 dec", tcnt, 2);
    cur_req = "R7";
    tick(t64); tick(tsec); chk("R7 other src ignored", tcnt, 2);
    cur_req = "R6";
    tick(t4k); tick(t4k); chk("R6 reload", tcnt, 3); chk("R6 TF", flags, 3'b001);
    cur_req = "R10";
    tie = 0; cyc(1); chk("R10 gated", irq_n, 1);
    tie = 1; cyc(1); chk("R10 enabled", irq_n, 0);
    wr_flags(3'b110); tie = 0;
    cur_req = "R7";
    tsrc = 2'd2; tick(t4k); chk("R7 4k ignored", tcnt, 3);
    tick(tsec); chk("R7 sec source", tcnt, 2);
    tsrc = 2'd3; tick(tmin); chk("R7 min source", tcnt, 1);
    tsrc = 2'd1; tick(t64); chk("R7 64 source", tcnt, 3);
    cur_req = "R8";
    tick(t64); tval = 9; tload = 1; t64 = 1; cyc(1); tload = 0; t64 = 0;
    chk("R8 mid-period load", tcnt, 9);
    cur_req = "R9";
    ten = 0; tick(t64); tick(t64); chk("R9 hold", tcnt, 9);
    tval = 0; tload = 1; cyc(1); tload = 0; ten = 1; tick(t64);
    cur_req = "R6"; chk("R6 zero stays", tcnt, 0);
    wr_flags(3'b000);

    // R11 pulse mode
    cur_req = "R11";
    pmode = 1; aie = 1; alm_en = 4'b0001; alm_min = 12;
    cur_min = 12; cyc(1); chk("R11 pulse start", irq_n, 0);
    cyc(PW); chk("R11 pulse end", irq_n, 1); chk("R11 flag kept", flags, 3'b010);
    wr_flags(3'b101); cur_min = 13; cyc(1);
    cur_min = 12; cyc(1); chk("R11 pulse again", irq_n, 0);
    wr_flags(3'b101); chk("R11 cut short", irq_n, 1);
    cyc(3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule